// File: doc/BRIEF.md
# Flash Bank Write-Busy Controller

This block runs one write operation at a time on a flash array split into four banks. It also guards bank accesses while that operation is in progress. Software sets up an operation through a small register bus: a target word address, a data word, and a control word that holds the start bit, a lock bit, an operation kind and a bank number. Once the operation starts, the target bank is marked busy. A behavioural cell-timing counter then runs for a fixed number of cycles and ends the operation. A program operation stores its data word when it completes. A protection operation changes no array data, but it always occupies bank 2.

While a bank is busy, a read of that bank returns invalid data (all ones) and raises a trap request that carries code 009Bh. A write to a busy bank is dropped. Single-cycle suspend and resume pulses pause and continue the operation, and the busy flag drops and returns with them. A supply-drop input cancels everything at once and puts every bank back in read mode. When the lock bit is set and an operation is pending, the control registers cannot be written.

Top module: `flash_wbusy_ctrl`

## Requirements
- R1: After reset, `status` is 0000h, and `op_done`, `acc_trap` and `trap_code` are all zero.
- R2: A control write (reg_addr 0) with bit 0 (go) set while no operation is pending starts an operation. From the next cycle, the busy flag of the bank in bits [5:4] is set and the lock flag takes bit 1 of the write. Only one busy flag is ever set.
- R3: When bit 2 (protect) of an accepted control write is set, bank 2 becomes busy whatever the bank field holds, and completion writes nothing to the array.
- R4: A read of a busy bank gives, one cycle later, `acc_rdata` all ones, `acc_trap` high for one cycle and `trap_code` 009Bh. A read of a bank that is not busy gives the stored word, with no trap and a code of zero.
- R5: A port write to a busy bank leaves the array unchanged.
- R6: An operation completes after OP_CYCLES cycles spent running. In the cycle after its last running cycle, its busy flag clears and `op_done` is high for exactly one cycle. A program operation stores the data register (reg_addr 2) at the word in the address register (reg_addr 1) of its bank.
- R7: A `sus_req` pulse while running clears the busy flag in the next cycle and freezes the cycle count. A `sus_req` pulse with no running operation has no effect.
- R8: A `res_req` pulse while suspended sets the same busy flag again in the next cycle, and counting continues from where it stopped. A `res_req` pulse with no suspended operation has no effect.
- R9: A go write while an operation is pending (running or suspended) is ignored and sets the error flag, status bit 8. The next accepted go clears the error flag.
- R10: While the lock flag is set and an operation is pending, every register write is dropped, including a write that would clear the lock.
- R11: `sup_low` cancels any running or suspended operation in the next cycle. All busy flags clear, no `op_done` is raised and nothing is written to the array. A later resume has no effect.
- R12: `status` places the bank 2 busy flag at bit 2, bank 3 at bit 3, the lock flag at bit 4, bank 0 at bit 6, bank 1 at bit 7 and the error flag at bit 8. All other bits read zero.
- R13: When a program completion and a port write to another bank fall on the same cycle, the completion data is stored and the port write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 word address, 2 data |
| reg_wdata | input | 16 | Register write data |
| sus_req | input | 1 | Suspend pulse |
| res_req | input | 1 | Resume pulse |
| sup_low | input | 1 | Supply-drop abort |
| acc_rd | input | 1 | Bank read strobe |
| acc_wr | input | 1 | Bank write strobe |
| acc_bank | input | 2 | Accessed bank |
| acc_addr | input | WORD_AW | Word within bank |
| acc_wdata | input | DW | Bank write data |
| status | output | 16 | Status word (read-only) |
| acc_rdata | output | DW | Read data, one cycle after acc_rd |
| acc_trap | output | 1 | Trap request for a busy-bank read |
| trap_code | output | 16 | Trap code, 009Bh while acc_trap |
| op_done | output | 1 | One-cycle completion strobe |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. Busy flags, the lock flag, the error flag, read data, the trap and its code all appear on the first edge after the strobe. The only exception is completion, which appears on the OP_CYCLES-th running edge after the start; suspended edges do not count toward it. The bench drives each stimulus at a falling edge and advances a behavioural model by one step for that stimulus. After the next rising edge it compares every output at the following falling edge. Read data is compared only in cycles that follow a read. Completion timing is exercised directly by placing a port write on the final running edge.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int NBANK     = 4;
  localparam int BANK_W    = 2;
  localparam int PROT_BANK = 2;
  localparam logic [15:0] TRAP_CODE = 16'h009B;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_PADDR = 2'd1;
  localparam logic [1:0] RA_PDATA = 2'd2;

  localparam int CB_GO   = 0;
  localparam int CB_LOCK = 1;
  localparam int CB_PROT = 2;
  localparam int CB_BANK = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SUSP} op_st_t;
endpackage

// File: rtl/fwb_cell_timer.sv
module fwb_cell_timer #(
  parameter int OP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic fin
);
  localparam int CW = $clog2(OP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OP_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  assign fin = run && (cnt == LAST);
endmodule

// File: rtl/fwb_sequencer.sv
module fwb_sequencer
  import fwb_pkg::*;
#(
  parameter int WORD_AW = 4,
  parameter int DW      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  input  logic               sus_req,
  input  logic               res_req,
  input  logic               sup_low,
  input  logic               fin,
  output logic               tm_clr,
  output logic               tm_run,
  output logic [NBANK-1:0]   busy,
  output logic [15:0]        status,
  output logic               op_done,
  output logic               prog_we,
  output logic [BANK_W-1:0]  prog_bank,
  output logic [WORD_AW-1:0] prog_addr,
  output logic [DW-1:0]      prog_data
);
  op_st_t              st;
  logic [BANK_W-1:0]   tgt_q;
  logic                prot_q, lock_q, err_q, done_q;
  logic [WORD_AW-1:0]  paddr_q;
  logic [DW-1:0]       pdata_q;
  logic                wr_ok, go_ok;

  assign wr_ok  = reg_we && !(lock_q && st != ST_IDLE);
  assign go_ok  = wr_ok && reg_addr == RA_CTRL && reg_wdata[CB_GO] && st == ST_IDLE;
  assign tm_clr = go_ok;
  assign tm_run = (st == ST_RUN) && !sus_req && !sup_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      tgt_q   <= '0;
      prot_q  <= 1'b0;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_RUN: begin
          if (sus_req) st <= ST_SUSP;
          else if (fin) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_SUSP: if (res_req) st <= ST_RUN;
        default: ;
      endcase
      if (wr_ok) begin
        case (reg_addr)
          RA_CTRL: begin
            if (reg_wdata[CB_GO]) begin
              if (st == ST_IDLE) begin
                st     <= ST_RUN;
                prot_q <= reg_wdata[CB_PROT];
                tgt_q  <= reg_wdata[CB_PROT] ? BANK_W'(PROT_BANK)
                                             : reg_wdata[CB_BANK +: BANK_W];
                lock_q <= reg_wdata[CB_LOCK];
                err_q  <= 1'b0;
              end else begin
                err_q <= 1'b1;
              end
            end else begin
              lock_q <= reg_wdata[CB_LOCK];
            end
          end
          RA_PADDR: paddr_q <= reg_wdata[WORD_AW-1:0];
          RA_PDATA: pdata_q <= reg_wdata[DW-1:0];
          default: ;
        endcase
      end
      if (sup_low) begin
        st     <= ST_IDLE;
        done_q <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_busy
    assign busy[b] = (st == ST_RUN) && (tgt_q == BANK_W'(b));
  end

  assign status = {7'd0, err_q, busy[1], busy[0], 1'b0, lock_q,
                   busy[3], busy[2], 2'b00};

  assign op_done   = done_q;
  assign prog_we   = fin && !prot_q;
  assign prog_bank = tgt_q;
  assign prog_addr = paddr_q;
  assign prog_data = pdata_q;
endmodule

// File: rtl/fwb_array.sv
module fwb_array
  import fwb_pkg::*;
#(
  parameter int WORD_AW = 4,
  parameter int DW      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NBANK-1:0]   busy,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [BANK_W-1:0]  acc_bank,
  input  logic [WORD_AW-1:0] acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  input  logic               prog_we,
  input  logic [BANK_W-1:0]  prog_bank,
  input  logic [WORD_AW-1:0] prog_addr,
  input  logic [DW-1:0]      prog_data,
  output logic [DW-1:0]      acc_rdata,
  output logic               acc_trap,
  output logic [15:0]        trap_code
);
  localparam int IW    = BANK_W + WORD_AW;
  localparam int DEPTH = NBANK << WORD_AW;

  logic [DW-1:0] mem [DEPTH];
  logic          we;
  logic [IW-1:0] widx, ridx;
  logic [DW-1:0] wdat;
  logic          hit_busy;

  assign hit_busy = busy[acc_bank];
  assign we   = prog_we || (acc_wr && !hit_busy);
  assign widx = prog_we ? {prog_bank, prog_addr} : {acc_bank, acc_addr};
  assign wdat = prog_we ? prog_data : acc_wdata;
  assign ridx = {acc_bank, acc_addr};

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
      acc_trap  <= 1'b0;
      trap_code <= '0;
    end else begin
      acc_trap  <= acc_rd && hit_busy;
      trap_code <= (acc_rd && hit_busy) ? TRAP_CODE : 16'h0000;
      if (acc_rd) acc_rdata <= hit_busy ? '1 : mem[ridx];
    end
  end
endmodule

// File: rtl/flash_wbusy_ctrl.sv
module flash_wbusy_ctrl
  import fwb_pkg::*;
#(
  parameter int WORD_AW   = 4,
  parameter int DW        = 16,
  parameter int OP_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  input  logic               sus_req,
  input  logic               res_req,
  input  logic               sup_low,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [1:0]         acc_bank,
  input  logic [WORD_AW-1:0] acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  output logic [15:0]        status,
  output logic [DW-1:0]      acc_rdata,
  output logic               acc_trap,
  output logic [15:0]        trap_code,
  output logic               op_done
);
  logic               tm_clr, tm_run, fin, prog_we;
  logic [NBANK-1:0]   busy;
  logic [BANK_W-1:0]  prog_bank;
  logic [WORD_AW-1:0] prog_addr;
  logic [DW-1:0]      prog_data;

  fwb_cell_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .clr(tm_clr), .run(tm_run), .fin(fin)
  );

  fwb_sequencer #(.WORD_AW(WORD_AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sus_req(sus_req), .res_req(res_req),
    .sup_low(sup_low), .fin(fin), .tm_clr(tm_clr), .tm_run(tm_run),
    .busy(busy), .status(status), .op_done(op_done), .prog_we(prog_we),
    .prog_bank(prog_bank), .prog_addr(prog_addr), .prog_data(prog_data)
  );

  fwb_array #(.WORD_AW(WORD_AW), .DW(DW)) u_array (
    .clk(clk), .rst(rst), .busy(busy), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_bank(acc_bank), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .prog_we(prog_we), .prog_bank(prog_bank), .prog_addr(prog_addr),
    .prog_data(prog_data), .acc_rdata(acc_rdata), .acc_trap(acc_trap),
    .trap_code(trap_code)
  );
endmodule

// File: rtl/fwb_ctrl_chk.sv
module fwb_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sup_low,
  input logic          acc_rd,
  input logic [15:0]   status,
  input logic [DW-1:0] acc_rdata,
  input logic          acc_trap,
  input logic [15:0]   trap_code,
  input logic          op_done
);
  logic [3:0] bflags;
  assign bflags = {status[3], status[2], status[7], status[6]};

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (rst) $countones(bflags) <= 1); // R2
  AST_TRAP_CODE: assert property (@(posedge clk) disable iff (rst) acc_trap |-> trap_code == 16'h009B); // R4
  AST_TRAP_DATA: assert property (@(posedge clk) disable iff (rst) acc_trap |-> &acc_rdata); // R4
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(acc_trap) |-> $past(acc_rd)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) op_done |=> !op_done); // R6
  AST_DONE_FREE: assert property (@(posedge clk) disable iff (rst) op_done |-> bflags == 4'd0); // R6
  AST_SUPPLY_ABORT: assert property (@(posedge clk) disable iff (rst) sup_low |=> (bflags == 4'd0 && !op_done)); // R11
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst) status[15:9] == 7'd0 && status[5] == 1'b0 && status[1:0] == 2'b00); // R12
endmodule

bind flash_wbusy_ctrl fwb_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sup_low(sup_low), .acc_rd(acc_rd), .status(status),
  .acc_rdata(acc_rdata), .acc_trap(acc_trap), .trap_code(trap_code),
  .op_done(op_done)
);

// File: tb/flash_wbusy_ctrl_tb.sv
`timescale 1ns/1ps
module flash_wbusy_ctrl_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int OPC = 8;
  localparam int WORDS = 1 << AW;

  logic clk = 0;
  always #4 clk = ~clk;

  logic          rst = 1;
  logic          reg_we = 0;
  logic [1:0]    reg_addr = 0;
  logic [15:0]   reg_wdata = 0;
  logic          sus_req = 0, res_req = 0, sup_low = 0;
  logic          acc_rd = 0, acc_wr = 0;
  logic [1:0]    acc_bank = 0;
  logic [AW-1:0] acc_addr = 0;
  logic [DW-1:0] acc_wdata = 0;
  logic [15:0]   status;
  logic [DW-1:0] acc_rdata;
  logic          acc_trap;
  logic [15:0]   trap_code;
  logic          op_done;

  flash_wbusy_ctrl #(.WORD_AW(AW), .DW(DW), .OP_CYCLES(OPC)) dut_i (.*);

  int vectors = 0, miscompares = 0;
  string cur_tag = "R1";

  // behavioural reference model
  int m_st = 0;          // 0 idle, 1 running, 2 suspended
  int m_tgt = 0, m_prot = 0, m_lock = 0, m_err = 0;
  int m_paddr = 0, m_pdata = 0, m_cnt = 0, m_done = 0;
  int m_trap = 0, m_rdata = 0, m_rdchk = 0;
  int m_mem [4*WORDS];

  function automatic int mbusy(int b);
    return (m_st == 1 && m_tgt == b) ? 1 : 0;
  endfunction

  function automatic int mstatus();
    return (mbusy(2) << 2) | (mbusy(3) << 3) | (m_lock << 4) |
           (mbusy(0) << 6) | (mbusy(1) << 7) | (m_err << 8);
  endfunction

  task automatic model_step();
    int fin, nst, ntgt, blocked;
    m_done = 0;
    m_rdchk = acc_rd;
    m_trap = 0;
    if (acc_rd) begin
      if (mbusy(acc_bank)) begin m_rdata = 16'hFFFF; m_trap = 1; end
      else m_rdata = m_mem[acc_bank*WORDS + acc_addr];
    end
    fin = (m_st == 1 && !sus_req && !sup_low && m_cnt == OPC-1);
    if (acc_wr && !mbusy(acc_bank) && !(fin && !m_prot))
      m_mem[acc_bank*WORDS + acc_addr] = acc_wdata;
    if (fin && !m_prot) m_mem[m_tgt*WORDS + m_paddr] = m_pdata;
    nst = m_st;
    if (m_st == 1 && sus_req) nst = 2;
    else if (m_st == 1 && fin) begin nst = 0; m_done = 1; end
    else if (m_st == 1) m_cnt++;
    else if (m_st == 2 && res_req) nst = 1;
    blocked = (m_lock && m_st != 0);
    if (reg_we && !blocked) begin
      if (reg_addr == 0) begin
        if (reg_wdata[0]) begin
          if (m_st == 0) begin
            nst = 1; m_cnt = 0; m_err = 0;
            m_prot = reg_wdata[2]; m_lock = reg_wdata[1];
            ntgt = reg_wdata[2] ? 2 : int'(reg_wdata[5:4]);
            m_tgt = ntgt;
          end else m_err = 1;
        end else m_lock = reg_wdata[1];
      end else if (reg_addr == 1) m_paddr = reg_wdata[AW-1:0];
      else if (reg_addr == 2) m_pdata = reg_wdata;
    end
    if (sup_low) begin nst = 0; m_done = 0; end
    m_st = nst;
  endtask

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("status", status, mstatus());
    chk("op_done", op_done, m_done);
    chk("acc_trap", acc_trap, m_trap);
    chk("trap_code", trap_code, m_trap ? 16'h009B : 0);
    if (m_rdchk) chk("acc_rdata", acc_rdata, m_rdata);
  endtask

  task automatic idle_inputs();
    reg_we = 0; sus_req = 0; res_req = 0; sup_low = 0;
    acc_rd = 0; acc_wr = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  task automatic regw(int a, int d);
    reg_we = 1; reg_addr = 2'(a); reg_wdata = 16'(d); tick();
  endtask

  task automatic rd(int b, int a);
    acc_rd = 1; acc_bank = 2'(b); acc_addr = AW'(a); tick();
  endtask

  task automatic wr(int b, int a, int d);
    acc_wr = 1; acc_bank = 2'(b); acc_addr = AW'(a); acc_wdata = DW'(d); tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    cur_tag = "R1";
    chk("status", status, 0);
    chk("op_done", op_done, 0);
    chk("acc_trap", acc_trap, 0);
    chk("trap_code", trap_code, 0);

    cur_tag = "R4";
    for (int i = 0; i < 4*WORDS; i++) wr(i / WORDS, i % WORDS, (i * 16'h0101) ^ 16'h5A00);
    rd(0, 3); rd(3, 15); rd(2, 0);

    // program operation on bank 1
    cur_tag = "R2";
    regw(1, 5); regw(2, 16'h1234); regw(0, 16'h0011);
    cur_tag = "R4"; rd(1, 5); rd(0, 3);
    cur_tag = "R5"; wr(1, 6, 16'hBEEF);
    cur_tag = "R9"; regw(0, 16'h0001);
    cur_tag = "R6"; idle(10); rd(1, 5);
    cur_tag = "R5"; rd(1, 6);

    // suspend / resume with nothing pending
    cur_tag = "R7"; sus_req = 1; tick();
    cur_tag = "R8"; res_req = 1; tick();

    // protection operation, bank field 3 but bank 2 marked busy
    cur_tag = "R3"; regw(0, 16'h0035); rd(2, 1);
    cur_tag = "R7"; sus_req = 1; tick(); rd(2, 1); idle(3); sus_req = 1; tick();
    cur_tag = "R8"; res_req = 1; tick(); rd(2, 1); res_req = 1; tick();
    cur_tag = "R3"; idle(12); rd(2, 1);

    // lock during a write
    cur_tag = "R10";
    regw(1, 3); regw(2, 16'hCAFE); regw(0, 16'h0033);
    regw(1, 9); regw(0, 0); regw(2, 16'h1111);
    sus_req = 1; tick(); regw(0, 0);
    res_req = 1; tick(); idle(12);
    rd(3, 3); regw(0, 0);
    cur_tag = "R12"; idle(1);

    // supply drop while running, then while suspended
    cur_tag = "R11";
    regw(1, 7); regw(2, 16'h7777); regw(0, 16'h0001);
    idle(3); sup_low = 1; tick(); idle(10);
    res_req = 1; tick(); rd(0, 7);
    regw(0, 16'h0021); sus_req = 1; tick(); sup_low = 1; tick();
    res_req = 1; tick(); idle(10); rd(2, 7);

    // completion and port write on the same edge
    cur_tag = "R13";
    regw(1, 2); regw(2, 16'hD00D); regw(0, 16'h0001);
    idle(OPC - 1);
    wr(3, 9, 16'h4444);
    rd(3, 9); rd(0, 2);
    cur_tag = "R9"; regw(0, 16'h0001); regw(0, 16'h0001); idle(10);

    summary();
  end
endmodule